// File: doc/BRIEF.md
# Half-Pixel Motion Compensation Predictor

This block forms an 8x8 predicted block of unsigned 8-bit pixels from reference rows that stream into it. A start pulse selects one of four interpolation modes (straight copy, horizontal half-pixel, vertical half-pixel, or diagonal half-pixel) and a rounding-control bit. Both are captured at that moment and held until the block completes.

Each input beat carries one reference row of nine bytes. Byte k sits at bits 8k+7:8k, and byte 0 is the leftmost pixel. Output beats carry one predicted row of eight pixels, packed the same way, under a valid/ready handshake. Rows leave in top-to-bottom order. The vertical and diagonal modes take one extra reference row: the first row only primes an internal per-lane history and produces no output.

In diagonal mode the history holds each lane's horizontal pair sum from the previous reference row, so every sum is computed once and reused for the next output row. Residue addition, memory fetch and motion-vector handling sit outside this block.

Top module: `hpel_predictor`

## Requirements
- R1: With mode code 0 (copy), output row j pixel k equals reference row j byte k; exactly 8 input rows are accepted and byte 8 of each row does not affect the output.
- R2: With mode code 1 (horizontal), output pixel (j,k) is (ref[j][k] + ref[j][k+1] + 1 - rnd) >> 1, using byte 8 for k = 7; exactly 8 input rows are accepted.
- R3: With mode code 2 (vertical), output pixel (j,k) is (ref[j][k] + ref[j+1][k] + 1 - rnd) >> 1; exactly 9 input rows are accepted, and the first produces no output.
- R4: With mode code 3 (diagonal), output pixel (j,k) is (ref[j][k] + ref[j][k+1] + ref[j+1][k] + ref[j+1][k+1] + 2 - rnd) >> 2; exactly 9 input rows are accepted.
- R5: Sums are formed without overflow, so reference values of 255 give 255 in every interpolating mode and for both rounding values.
- R6: In copy mode the rounding-control input has no effect on the output.
- R7: Changes on mode and rnd, and further start pulses, while a block is in progress do not alter that block's results.
- R8: Output rows leave in order 0 to 7. While out_valid is high and out_ready is low, out_valid stays high and out_row is unchanged.
- R9: done is high for exactly one cycle, the cycle after the eighth output row is accepted, and busy is low from that cycle on.
- R10: in_ready is low whenever no block is in progress and once the mode's required rows have all been accepted, so surplus rows offered are never taken.
- R11: After reset, out_valid, done, in_ready and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a block when idle |
| mode | input | 2 | Interpolation mode code, sampled at start: 0 copy, 1 horizontal, 2 vertical, 3 diagonal |
| rnd | input | 1 | Rounding control, sampled at start: 0 rounds up, 1 biases down |
| in_valid | input | 1 | Reference row present |
| in_ready | output | 1 | Block accepts a reference row |
| in_row | input | 72 | Nine reference bytes, byte k at bits 8k+7:8k |
| out_valid | output | 1 | Predicted row present |
| out_ready | input | 1 | Consumer takes the predicted row |
| out_row | output | 64 | Eight predicted pixels, pixel k at bits 8k+7:8k |
| done | output | 1 | One-cycle pulse after the last row is taken |
| busy | output | 1 | A block is in progress |

## Verification
A corrupted history register cannot hide. In vertical and diagonal modes it feeds every lane of the next output row, so a wrong value shows up on out_row at the very next produced beat. A miscounted row counter shows up as one of three symptoms: an extra or missing accepted input row, a missing output row, or a done pulse that comes early or late. The bench catches each of these within one block by counting rows offered against rows taken. A mode or rounding register that changes mid-block alters the pixel arithmetic of the following row, so the bench scrambles those inputs during a block to expose it.

// File: rtl/hpel_pkg.sv
package hpel_pkg;

    localparam int PIX_BITS  = 8;
    localparam int ROW_LANES = 8;
    localparam int BLK_LINES = 8;

    typedef enum logic [1:0] {
        MODE_COPY    = 2'd0,
        MODE_HALF_X  = 2'd1,
        MODE_HALF_Y  = 2'd2,
        MODE_HALF_XY = 2'd3
    } pred_mode_e;

    // Modes that consume one extra reference row to prime the history.
    function automatic logic needs_prev_row(pred_mode_e m);
        return (m == MODE_HALF_Y) || (m == MODE_HALF_XY);
    endfunction

    // Bias added before halving a two-pixel sum.
    function automatic logic [0:0] bias_pair(logic rnd);
        return rnd ? 1'b0 : 1'b1;
    endfunction

    // Bias added before quartering a four-pixel sum.
    function automatic logic [1:0] bias_quad(logic rnd);
        return rnd ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/hpel_lane.sv
module hpel_lane
    import hpel_pkg::*;
#(
    parameter int PIX_W = PIX_BITS
) (
    input  pred_mode_e       mode,
    input  logic             rnd,
    input  logic [PIX_W-1:0] cur_a,
    input  logic [PIX_W-1:0] cur_b,
    input  logic [PIX_W:0]   hist,
    output logic [PIX_W-1:0] pix,
    output logic [PIX_W:0]   hist_next
);
    localparam int SUM_W = PIX_W + 1;

    logic [SUM_W-1:0] pair_sum;
    logic [SUM_W-1:0] hx_sum;
    logic [SUM_W-1:0] hy_sum;
    logic [SUM_W:0]   quad_sum;

    always_comb begin
        pair_sum  = {1'b0, cur_a} + {1'b0, cur_b};
        hx_sum    = pair_sum + SUM_W'(bias_pair(rnd));
        hy_sum    = {1'b0, hist[PIX_W-1:0]} + {1'b0, cur_a} + SUM_W'(bias_pair(rnd));
        quad_sum  = {1'b0, hist} + {1'b0, pair_sum} + (SUM_W+1)'(bias_quad(rnd));
        hist_next = (mode == MODE_HALF_XY) ? pair_sum : {1'b0, cur_a};
        unique case (mode)
            MODE_COPY:   pix = cur_a;
            MODE_HALF_X: pix = hx_sum[SUM_W-1:1];
            MODE_HALF_Y: pix = hy_sum[SUM_W-1:1];
            default:     pix = quad_sum[SUM_W:2];
        endcase
    end

endmodule

// File: rtl/hpel_row_filter.sv
module hpel_row_filter
    import hpel_pkg::*;
#(
    parameter int PIX_W = PIX_BITS,
    parameter int LANES = ROW_LANES
) (
    input  pred_mode_e                   mode,
    input  logic                         rnd,
    input  logic [(LANES+1)*PIX_W-1:0]   ref_row,
    input  logic [LANES*(PIX_W+1)-1:0]   hist_q,
    output logic [LANES*PIX_W-1:0]       pred_row,
    output logic [LANES*(PIX_W+1)-1:0]   hist_d
);
    localparam int SUM_W = PIX_W + 1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        hpel_lane #(.PIX_W(PIX_W)) i_lane (
            .mode      (mode),
            .rnd       (rnd),
            .cur_a     (ref_row[k*PIX_W +: PIX_W]),
            .cur_b     (ref_row[(k+1)*PIX_W +: PIX_W]),
            .hist      (hist_q[k*SUM_W +: SUM_W]),
            .pix       (pred_row[k*PIX_W +: PIX_W]),
            .hist_next (hist_d[k*SUM_W +: SUM_W])
        );
    end

endmodule

// File: rtl/hpel_ctrl.sv
module hpel_ctrl
    import hpel_pkg::*;
#(
    parameter int LINES = BLK_LINES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] mode_in,
    input  logic       rnd_in,
    input  logic       in_valid,
    input  logic       out_ready,
    output logic       in_ready,
    output logic       in_fire,
    output logic       produce,
    output logic       out_valid,
    output logic       done,
    output logic       busy,
    output pred_mode_e mode_q,
    output logic       rnd_q
);
    localparam int ICW = $clog2(LINES + 2);
    localparam int OCW = $clog2(LINES + 1);

    logic [ICW-1:0] in_cnt;
    logic [OCW-1:0] out_cnt;
    logic [ICW-1:0] need_rows;
    logic           prime;
    logic           out_fire;
    logic           last_out;

    always_comb begin
        need_rows = needs_prev_row(mode_q) ? ICW'(LINES + 1) : ICW'(LINES);
        in_ready  = busy && (in_cnt < need_rows) && (!out_valid || out_ready);
        in_fire   = in_valid && in_ready;
        prime     = in_fire && needs_prev_row(mode_q) && (in_cnt == '0);
        produce   = in_fire && !prime;
        out_fire  = out_valid && out_ready;
        last_out  = out_fire && (out_cnt == OCW'(LINES - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            out_valid <= 1'b0;
            in_cnt    <= '0;
            out_cnt   <= '0;
            mode_q    <= MODE_COPY;
            rnd_q     <= 1'b0;
        end else begin
            done <= last_out;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    mode_q  <= pred_mode_e'(mode_in);
                    rnd_q   <= rnd_in;
                    in_cnt  <= '0;
                    out_cnt <= '0;
                end
            end else begin
                if (in_fire)
                    in_cnt <= in_cnt + 1'b1;
                if (out_fire)
                    out_cnt <= out_cnt + 1'b1;
                if (last_out)
                    busy <= 1'b0;
            end
            if (produce)
                out_valid <= 1'b1;
            else if (out_fire)
                out_valid <= 1'b0;
        end
    end

    // R9: a single done pulse follows the final accepted row, block ends.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        last_out |=> done && !busy);
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: captured mode and rounding never move inside a block.
    p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy && !last_out |=> $stable(mode_q) && $stable(rnd_q));

    // R10: nothing is accepted or offered outside a block.
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !in_ready && !out_valid);

    // R10: the accepted-row count never passes the mode's requirement.
    p_row_limit_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> in_cnt <= need_rows);

endmodule

// File: rtl/hpel_predictor.sv
module hpel_predictor
    import hpel_pkg::*;
#(
    parameter int PIX_W = PIX_BITS,
    parameter int LANES = ROW_LANES,
    parameter int LINES = BLK_LINES
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [1:0]                 mode,
    input  logic                       rnd,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [(LANES+1)*PIX_W-1:0] in_row,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic [LANES*PIX_W-1:0]     out_row,
    output logic                       done,
    output logic                       busy
);
    localparam int HIST_W = LANES * (PIX_W + 1);

    pred_mode_e                 mode_q;
    logic                       rnd_q;
    logic                       in_fire;
    logic                       produce;
    logic [HIST_W-1:0]          hist_q;
    logic [HIST_W-1:0]          hist_d;
    logic [LANES*PIX_W-1:0]     pred_row;
    logic [LANES*PIX_W-1:0]     out_row_q;

    hpel_ctrl #(.LINES(LINES)) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_in   (mode),
        .rnd_in    (rnd),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .in_fire   (in_fire),
        .produce   (produce),
        .out_valid (out_valid),
        .done      (done),
        .busy      (busy),
        .mode_q    (mode_q),
        .rnd_q     (rnd_q)
    );

    hpel_row_filter #(.PIX_W(PIX_W), .LANES(LANES)) i_filter (
        .mode     (mode_q),
        .rnd      (rnd_q),
        .ref_row  (in_row),
        .hist_q   (hist_q),
        .pred_row (pred_row),
        .hist_d   (hist_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q    <= '0;
            out_row_q <= '0;
        end else begin
            if (in_fire)
                hist_q <= hist_d;
            if (produce)
                out_row_q <= pred_row;
        end
    end

    assign out_row = out_row_q;

    // R8: a stalled output row is held unchanged.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_row));

endmodule

// File: tb/test_hpel_predictor.sv
module test_hpel_predictor;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [1:0]  mode;
    logic        rnd;
    logic        in_valid;
    logic        in_ready;
    logic [71:0] in_row;
    logic        out_valid;
    logic        out_ready;
    logic [63:0] out_row;
    logic        done;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit blk_over;
    int rows_taken;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hpel_predictor i_hpel_predictor (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .rnd(rnd),
        .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
        .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
        .done(done), .busy(busy)
    );

    function automatic int px(int seed, int r, int c);
        if (seed == 0) return 255;
        return (seed * 37 + r * 29 + c * 53 + r * c * 11 + (r ^ c) * 7) % 256;
    endfunction

    function automatic logic [71:0] ref_row(int seed, int r);
        logic [71:0] v;
        for (int c = 0; c < 9; c++) v[c*8 +: 8] = 8'(px(seed, r, c));
        return v;
    endfunction

    function automatic logic [63:0] exp_row(int m, int rn, int seed, int j);
        logic [63:0] v;
        for (int k = 0; k < 8; k++) begin
            int a, b, c, d, p;
            a = px(seed, j, k);     b = px(seed, j, k + 1);
            c = px(seed, j + 1, k); d = px(seed, j + 1, k + 1);
            case (m)
                0: p = a;
                1: p = (a + b + 1 - rn) >> 1;
                2: p = (a + c + 1 - rn) >> 1;
                default: p = (a + b + c + d + 2 - rn) >> 2;
            endcase
            v[k*8 +: 8] = 8'(p);
        end
        return v;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic t_reset(string req);
        rst = 1'b1; start = 1'b0; mode = 2'd0; rnd = 1'b0;
        in_valid = 1'b0; in_row = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        check(!out_valid && !done && !in_ready && !busy, req, "reset state",
              {60'd0, out_valid, done, in_ready, busy}, 64'd0);
        // R10: idle block refuses an offered row
        in_valid = 1'b1; #1;
        check(!in_ready, "R10", "idle in_ready", {63'd0, in_ready}, 64'd0);
        @(negedge clk); in_valid = 1'b0;
    endtask

    // One block: start, stream rows, collect and check every output row.
    task automatic run_block(string req, int m, int rn, int seed, bit stall, bit gaps, bit scramble);
        int need;
        need = (m >= 2) ? 9 : 8;
        blk_over = 1'b0;
        rows_taken = 0;
        @(negedge clk);
        start = 1'b1; mode = 2'(m); rnd = 1'(rn);
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin mode = ~2'(m); rnd = ~1'(rn); end
        fork
            begin : feeder
                int r = 0;
                while (!blk_over) begin
                    @(negedge clk);
                    if (gaps && (cyc % 4 == 2)) begin
                        in_valid = 1'b0;
                    end else begin
                        in_valid = 1'b1;
                        in_row = ref_row(seed, r);
                        #1;
                        if (in_ready) r++;
                    end
                end
                in_valid = 1'b0;
                rows_taken = r;
            end
            begin : collector
                int j = 0;
                bit held = 1'b0;
                logic [63:0] held_row;
                while (j < 8) begin
                    @(negedge clk);
                    out_ready = (stall && (cyc % 3 == 1)) ? 1'b0 : 1'b1;
                    #2;
                    if (held)
                        check(out_valid && out_row == held_row, "R8", "stall hold",
                              out_row, held_row);
                    held = 1'b0;
                    if (out_valid && out_ready) begin
                        check(out_row == exp_row(m, rn, seed, j), req,
                              $sformatf("row %0d", j), out_row, exp_row(m, rn, seed, j));
                        j++;
                    end else if (out_valid) begin
                        held = 1'b1;
                        held_row = out_row;
                    end
                end
                @(negedge clk); #2;
                check(done && !busy, "R9", "done pulse", {62'd0, done, busy}, 64'd2);
                @(negedge clk); #2;
                check(!done && !out_valid && !in_ready, "R9", "done single",
                      {61'd0, done, out_valid, in_ready}, 64'd0);
                blk_over = 1'b1;
            end
            begin : disturber
                if (scramble) begin
                    repeat (5) @(negedge clk);
                    start = 1'b1; mode = 2'(m + 1); rnd = ~1'(rn);
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        join
        check(rows_taken == need, "R10", "rows accepted", 64'(rows_taken), 64'(need));
        out_ready = 1'b0;
    endtask

    initial begin
        t_reset("R11");
        run_block("R1", 0, 0, 3, 0, 0, 0);
        run_block("R6", 0, 1, 3, 0, 0, 0);
        run_block("R2", 1, 0, 5, 0, 0, 0);
        run_block("R2", 1, 1, 6, 1, 1, 0);
        run_block("R3", 2, 0, 7, 0, 0, 0);
        run_block("R3", 2, 1, 8, 1, 0, 0);
        run_block("R4", 3, 0, 9, 0, 0, 0);
        run_block("R4", 3, 1, 10, 1, 1, 0);
        run_block("R5", 3, 0, 0, 0, 0, 0);
        run_block("R5", 1, 0, 0, 0, 0, 0);
        run_block("R5", 2, 1, 0, 0, 0, 0);
        run_block("R7", 3, 1, 11, 0, 0, 1);
        run_block("R7", 1, 0, 12, 1, 0, 1);
        run_block("R8", 2, 0, 13, 1, 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule